// File: doc/BRIEF.md
# Operand Location Resolver

This block turns the operand fields of one instruction for a 16-bit processor into effective locations. Each location is one of three kinds: a register, a RAM address, or an immediate literal. The second operand field is 5 bits wide and is resolved first. The first operand field is 6 bits wide and is resolved second. The caller pulses `start` with both fields, the general register file, the stack pointer and the two instruction words that follow the opcode word. The block then reports one result per operand on consecutive cycles. Instruction fetch and the memory access itself stay outside the block.

A small sequencer carries the context from the first operand to the second. That context is the stack pointer as modified so far, which of the two trailing words comes next, and the extra-cycle count so far. This context gives the push/pop and next-word modes their ordering. The sequencer has three states:

- `ST_IDLE` waits for `start`. If `has_b` is 1 it moves to `ST_OPB`; otherwise it moves to `ST_OPA`.
- `ST_OPB` resolves the second operand and always moves to `ST_OPA`.
- `ST_OPA` resolves the first operand, raises `done` with the totals, and returns to `ST_IDLE`.

Result encodings:

- Location kind `res_kind`: 0 is literal (nothing to write; a write to it is dropped), 1 is register, 2 is RAM.
- Register index `res_reg`: 0–7 are the general registers, 8 is SP, 9 is PC, 10 is EX.
- `res_sp_adj`: 2'b00 is no change, 2'b01 is +1, 2'b11 is −1.
- All address arithmetic wraps modulo 2^16.

Top module: `operand_locator`

## Requirements
- R1: Field codes 0x00–0x07 give kind register (1) with index equal to the code. They use no extra word, no extra cycle and no SP change.
- R2: Codes 0x08–0x0f give kind RAM at the value of general register (code & 7), with no extra word.
- R3: Codes 0x10–0x17 give kind RAM at (next word + general register (code & 7)) mod 2^16. They consume one word and cost one extra cycle.
- R4: Code 0x18 behaves differently for the two operands. In the second (5-bit) operand it gives RAM at SP−1 with `res_sp_adj` = 2'b11. In the first (6-bit) operand it gives RAM at SP with `res_sp_adj` = 2'b01. The first operand sees SP as already adjusted by the second operand.
- R5: Code 0x19 gives RAM at SP with no SP change. Code 0x1a gives RAM at (SP + next word) mod 2^16, consumes one word and costs one extra cycle.
- R6: Codes 0x1b, 0x1c and 0x1d give kind register with indices 8 (SP), 9 (PC) and 10 (EX).
- R7: Code 0x1e gives RAM at the next word. Code 0x1f gives kind literal with the next word as its value. Each consumes one word and costs one extra cycle.
- R8: First-operand codes 0x20–0x3f give kind literal with value ((code & 0x1f) − 1) mod 2^16, so 0x20 yields 0xffff. Any non-literal result reports a literal value of 0.
- R9: The first operand that consumes a word takes `ext_word0`. The first operand takes `ext_word1` only when the second operand has already consumed `ext_word0`.
- R10: With `has_b`=1, the second-operand result appears one cycle after the `start` edge and the first-operand result one cycle later, together with `done`. With `has_b`=0, only the first-operand result appears, one cycle after `start`. A `start` pulse while `busy` is ignored, and no result appears while idle.
- R11: After reset, `busy`, `res_valid` and `done` are 0 and every result and total output is 0.
- R12: With `done`, `sum_words` and `sum_cycles` give the total words consumed and the total extra cycles. `sp_final` gives the input SP after both adjustments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin resolving one instruction's operands |
| has_b | input | 1 | The instruction carries a second (5-bit) operand |
| b_field | input | 5 | Second operand code |
| a_field | input | 6 | First operand code |
| gpr_bus | input | 128 | Eight general registers, register i in bits 16i+15:16i |
| sp_in | input | 16 | Stack pointer before the instruction |
| ext_word0 | input | 16 | Word directly after the opcode word |
| ext_word1 | input | 16 | Word after ext_word0 |
| busy | output | 1 | Sequencer not idle |
| res_valid | output | 1 | One operand result is presented |
| res_is_a | output | 1 | The result belongs to the first operand |
| res_kind | output | 2 | Location kind (0 literal, 1 register, 2 RAM) |
| res_reg | output | 4 | Register index (0–7 general, 8 SP, 9 PC, 10 EX) |
| res_addr | output | 16 | RAM address |
| res_literal | output | 16 | Literal value |
| res_word_used | output | 1 | This operand consumed a trailing word |
| res_sp_adj | output | 2 | SP change by this operand |
| res_extra_cyc | output | 2 | Extra cycles caused by this operand |
| done | output | 1 | Last result of the instruction; totals valid |
| sum_words | output | 2 | Trailing words consumed by the instruction |
| sum_cycles | output | 2 | Extra cycles for the instruction |
| sp_final | output | 16 | SP after both operands |

## Verification
On every cycle, the assertions check the consistency rules that tie a result's fields together:

- A register result never consumes a word and never moves SP.
- Only RAM results move SP.
- The extra cycle count always equals the word usage.
- A non-literal result has a zero literal value.
- Register indices stay in range.
- Ordering: a second-operand result is always followed by a first-operand result carrying `done`, and nothing appears after an idle cycle.

The address values, literal values and word selection can only be shown by the bench's scenarios. The bench sweeps all 32 × 64 field pairs, plus the single-operand form, with stack pointer and word values chosen to make the additions wrap. It also shows the rejection of `start` while busy.

// File: rtl/opl_pkg.sv
package opl_pkg;
    typedef enum logic [1:0] {
        LOC_NONE = 2'd0,
        LOC_REG  = 2'd1,
        LOC_RAM  = 2'd2
    } loc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OPB  = 2'd1,
        ST_OPA  = 2'd2
    } seq_state_e;

    localparam int REG_IDX_W = 4;
    localparam logic [REG_IDX_W-1:0] IDX_SP = 4'd8;
    localparam logic [REG_IDX_W-1:0] IDX_PC = 4'd9;
    localparam logic [REG_IDX_W-1:0] IDX_EX = 4'd10;

    localparam logic [1:0] ADJ_NONE = 2'b00;
    localparam logic [1:0] ADJ_INC  = 2'b01;
    localparam logic [1:0] ADJ_DEC  = 2'b11;
endpackage

// File: rtl/opl_gpr_mux.sv
module opl_gpr_mux #(
    parameter int WORD_W = 16,
    parameter int NGPR   = 8,
    localparam int IDX_W = $clog2(NGPR)
) (
    input  logic [NGPR*WORD_W-1:0] gpr_flat,
    input  logic [IDX_W-1:0]       sel,
    output logic [WORD_W-1:0]      value
);
    logic [WORD_W-1:0] bank [NGPR];

    for (genvar g = 0; g < NGPR; g++) begin : g_unpack
        assign bank[g] = gpr_flat[g*WORD_W +: WORD_W];
    end

    assign value = bank[sel];
endmodule

// File: rtl/opl_field_decode.sv
module opl_field_decode
    import opl_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int CYC_W  = 2
) (
    input  logic [5:0]           code,
    input  logic                 is_a,
    input  logic [WORD_W-1:0]    gval,
    input  logic [WORD_W-1:0]    sp,
    input  logic [WORD_W-1:0]    word,
    output loc_kind_e            kind,
    output logic [REG_IDX_W-1:0] reg_idx,
    output logic [WORD_W-1:0]    addr,
    output logic [WORD_W-1:0]    literal,
    output logic                 word_used,
    output logic [1:0]           sp_adj,
    output logic [CYC_W-1:0]     extra_cyc
);
    logic [WORD_W-1:0] short_lit;

    assign short_lit = WORD_W'(code[4:0]) - WORD_W'(1);

    always_comb begin
        kind      = LOC_NONE;
        reg_idx   = '0;
        addr      = '0;
        literal   = '0;
        word_used = 1'b0;
        sp_adj    = ADJ_NONE;
        if (code[5]) begin
            literal = short_lit;
        end else begin
            unique case (code[4:3])
                2'd0: begin
                    kind    = LOC_REG;
                    reg_idx = REG_IDX_W'(code[2:0]);
                end
                2'd1: begin
                    kind = LOC_RAM;
                    addr = gval;
                end
                2'd2: begin
                    kind      = LOC_RAM;
                    addr      = word + gval;
                    word_used = 1'b1;
                end
                default: begin
                    unique case (code[2:0])
                        3'd0: begin
                            kind = LOC_RAM;
                            if (is_a) begin
                                addr   = sp;
                                sp_adj = ADJ_INC;
                            end else begin
                                addr   = sp - WORD_W'(1);
                                sp_adj = ADJ_DEC;
                            end
                        end
                        3'd1: begin
                            kind = LOC_RAM;
                            addr = sp;
                        end
                        3'd2: begin
                            kind      = LOC_RAM;
                            addr      = sp + word;
                            word_used = 1'b1;
                        end
                        3'd3: begin
                            kind    = LOC_REG;
                            reg_idx = IDX_SP;
                        end
                        3'd4: begin
                            kind    = LOC_REG;
                            reg_idx = IDX_PC;
                        end
                        3'd5: begin
                            kind    = LOC_REG;
                            reg_idx = IDX_EX;
                        end
                        3'd6: begin
                            kind      = LOC_RAM;
                            addr      = word;
                            word_used = 1'b1;
                        end
                        default: begin
                            literal   = word;
                            word_used = 1'b1;
                        end
                    endcase
                end
            endcase
        end
    end

    assign extra_cyc = CYC_W'(word_used);
endmodule

// File: rtl/operand_locator.sv
module operand_locator
    import opl_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int NGPR   = 8,
    parameter int CYC_W  = 2,
    localparam int GIDX_W = $clog2(NGPR),
    localparam int WCNT_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   has_b,
    input  logic [4:0]             b_field,
    input  logic [5:0]             a_field,
    input  logic [NGPR*WORD_W-1:0] gpr_bus,
    input  logic [WORD_W-1:0]      sp_in,
    input  logic [WORD_W-1:0]      ext_word0,
    input  logic [WORD_W-1:0]      ext_word1,
    output logic                   busy,
    output logic                   res_valid,
    output logic                   res_is_a,
    output logic [1:0]             res_kind,
    output logic [REG_IDX_W-1:0]   res_reg,
    output logic [WORD_W-1:0]      res_addr,
    output logic [WORD_W-1:0]      res_literal,
    output logic                   res_word_used,
    output logic [1:0]             res_sp_adj,
    output logic [CYC_W-1:0]       res_extra_cyc,
    output logic                   done,
    output logic [WCNT_W-1:0]      sum_words,
    output logic [CYC_W-1:0]       sum_cycles,
    output logic [WORD_W-1:0]      sp_final
);
    seq_state_e st_q, st_d;

    logic [4:0]             b_q;
    logic [5:0]             a_q;
    logic [NGPR*WORD_W-1:0] gpr_q;
    logic [WORD_W-1:0]      sp_q, w0_q, w1_q;
    logic [WCNT_W-1:0]      wcnt_q;
    logic [CYC_W-1:0]       cyc_q;

    logic [5:0]             cur_code;
    logic                   cur_is_a;
    logic [WORD_W-1:0]      cur_word, gval, sp_next;
    loc_kind_e              dec_kind;
    logic [REG_IDX_W-1:0]   dec_reg;
    logic [WORD_W-1:0]      dec_addr, dec_lit;
    logic                   dec_used;
    logic [1:0]             dec_adj;
    logic [CYC_W-1:0]       dec_cyc;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_d = has_b ? ST_OPB : ST_OPA;
            ST_OPB:  st_d = ST_OPA;
            ST_OPA:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    assign busy     = (st_q != ST_IDLE);
    assign cur_code = (st_q == ST_OPB) ? {1'b0, b_q} : a_q;
    assign cur_is_a = (st_q != ST_OPB);
    assign cur_word = (wcnt_q != '0) ? w1_q : w0_q;

    opl_gpr_mux #(.WORD_W(WORD_W), .NGPR(NGPR)) u_gpr_mux (
        .gpr_flat (gpr_q),
        .sel      (cur_code[GIDX_W-1:0]),
        .value    (gval)
    );

    opl_field_decode #(.WORD_W(WORD_W), .CYC_W(CYC_W)) u_field_decode (
        .code      (cur_code),
        .is_a      (cur_is_a),
        .gval      (gval),
        .sp        (sp_q),
        .word      (cur_word),
        .kind      (dec_kind),
        .reg_idx   (dec_reg),
        .addr      (dec_addr),
        .literal   (dec_lit),
        .word_used (dec_used),
        .sp_adj    (dec_adj),
        .extra_cyc (dec_cyc)
    );

    always_comb begin
        unique case (dec_adj)
            ADJ_INC: sp_next = sp_q + WORD_W'(1);
            ADJ_DEC: sp_next = sp_q - WORD_W'(1);
            default: sp_next = sp_q;
        endcase
    end

    // Operand context: latched at start, advanced after the second operand
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q    <= '0;
            a_q    <= '0;
            gpr_q  <= '0;
            sp_q   <= '0;
            w0_q   <= '0;
            w1_q   <= '0;
            wcnt_q <= '0;
            cyc_q  <= '0;
        end else if (st_q == ST_IDLE && start) begin
            b_q    <= b_field;
            a_q    <= a_field;
            gpr_q  <= gpr_bus;
            sp_q   <= sp_in;
            w0_q   <= ext_word0;
            w1_q   <= ext_word1;
            wcnt_q <= '0;
            cyc_q  <= '0;
        end else if (st_q == ST_OPB) begin
            sp_q   <= sp_next;
            wcnt_q <= WCNT_W'(dec_used);
            cyc_q  <= dec_cyc;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid     <= 1'b0;
            res_is_a      <= 1'b0;
            res_kind      <= '0;
            res_reg       <= '0;
            res_addr      <= '0;
            res_literal   <= '0;
            res_word_used <= 1'b0;
            res_sp_adj    <= '0;
            res_extra_cyc <= '0;
            done          <= 1'b0;
            sum_words     <= '0;
            sum_cycles    <= '0;
            sp_final      <= '0;
        end else if (st_q == ST_OPB || st_q == ST_OPA) begin
            res_valid     <= 1'b1;
            res_is_a      <= cur_is_a;
            res_kind      <= dec_kind;
            res_reg       <= dec_reg;
            res_addr      <= dec_addr;
            res_literal   <= dec_lit;
            res_word_used <= dec_used;
            res_sp_adj    <= dec_adj;
            res_extra_cyc <= dec_cyc;
            done          <= cur_is_a;
            if (cur_is_a) begin
                sum_words  <= wcnt_q + WCNT_W'(dec_used);
                sum_cycles <= cyc_q + dec_cyc;
                sp_final   <= sp_next;
            end
        end else begin
            res_valid <= 1'b0;
            done      <= 1'b0;
        end
    end

    p_reg_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == LOC_REG) |-> (!res_word_used && res_sp_adj == ADJ_NONE))
        else $error("register result used a word or moved SP");

    p_word_cost_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_extra_cyc == CYC_W'(res_word_used)))
        else $error("extra cycles disagree with word usage");

    p_sp_ram_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_sp_adj != ADJ_NONE) |-> (res_kind == LOC_RAM && !res_word_used))
        else $error("SP moved by a non-stack result");

    p_reg_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == LOC_REG) |-> (res_reg <= IDX_EX))
        else $error("register index out of range");

    p_lit_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind != LOC_NONE) |-> (res_literal == '0))
        else $error("literal set on a non-literal result");

    p_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_is_a) |=> (res_valid && res_is_a && done))
        else $error("second-operand result not followed by first");

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !res_valid)
        else $error("result produced from idle");

    p_totals_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sum_cycles == CYC_W'(sum_words)))
        else $error("totals disagree");
endmodule

// File: tb/test_operand_locator.sv
module test_operand_locator;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, has_b = 1'b0;
    logic [4:0] b_field = '0;
    logic [5:0] a_field = '0;
    logic [127:0] gpr_bus = '0;
    logic [15:0] sp_in = '0, ext_word0 = '0, ext_word1 = '0;
    logic busy, res_valid, res_is_a, res_word_used, done;
    logic [1:0] res_kind, res_sp_adj, res_extra_cyc, sum_words, sum_cycles;
    logic [3:0] res_reg;
    logic [15:0] res_addr, res_literal, sp_final;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [15:0] gpr_val [8];

    always #10 clk = ~clk;

    operand_locator i_operand_locator (
        .clk(clk), .rst_n(rst_n), .start(start), .has_b(has_b),
        .b_field(b_field), .a_field(a_field), .gpr_bus(gpr_bus),
        .sp_in(sp_in), .ext_word0(ext_word0), .ext_word1(ext_word1),
        .busy(busy), .res_valid(res_valid), .res_is_a(res_is_a),
        .res_kind(res_kind), .res_reg(res_reg), .res_addr(res_addr),
        .res_literal(res_literal), .res_word_used(res_word_used),
        .res_sp_adj(res_sp_adj), .res_extra_cyc(res_extra_cyc),
        .done(done), .sum_words(sum_words), .sum_cycles(sum_cycles),
        .sp_final(sp_final)
    );

    // {kind, reg, addr, literal, used, adj, cyc}
    function automatic logic [42:0] model(input int c, input bit is_a,
                                          input logic [15:0] sp, input logic [15:0] w);
        logic [1:0] k = 2'd0;
        logic [3:0] ix = 4'd0;
        logic [15:0] ad = 16'd0, li = 16'd0;
        logic u = 1'b0;
        logic [1:0] aj = 2'b00;
        if (c >= 32) li = 16'(c - 33);
        else if (c < 8) begin k = 2'd1; ix = 4'(c); end
        else if (c < 16) begin k = 2'd2; ad = gpr_val[c-8]; end
        else if (c < 24) begin k = 2'd2; ad = 16'(w + gpr_val[c-16]); u = 1'b1; end
        else if (c == 24) begin
            k = 2'd2;
            if (is_a) begin ad = sp; aj = 2'b01; end
            else begin ad = 16'(sp - 16'd1); aj = 2'b11; end
        end
        else if (c == 25) begin k = 2'd2; ad = sp; end
        else if (c == 26) begin k = 2'd2; ad = 16'(sp + w); u = 1'b1; end
        else if (c <= 29) begin k = 2'd1; ix = 4'(c - 19); end
        else if (c == 30) begin k = 2'd2; ad = w; u = 1'b1; end
        else begin li = w; u = 1'b1; end
        return {k, ix, ad, li, u, aj, 1'b0, u};
    endfunction

    function automatic string req_of(input int c);
        if (c >= 32) return "R8";
        if (c < 8) return "R1";
        if (c < 16) return "R2";
        if (c < 24) return "R3";
        if (c == 24) return "R4";
        if (c <= 26) return "R5";
        if (c <= 29) return "R6";
        return "R7";
    endfunction

    function automatic logic [42:0] actual();
        return {res_kind, res_reg, res_addr, res_literal, res_word_used, res_sp_adj, res_extra_cyc};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_inst(input int b, input int a, input bit hb,
                            input logic [15:0] sp, input logic [15:0] w0, input logic [15:0] w1);
        logic [42:0] eb, ea;
        logic [15:0] sp_a, wa;
        logic [1:0] uw, cy;
        string tag;
        eb = model(b, 1'b0, sp, w0);
        sp_a = sp; wa = w0; uw = 2'd0;
        if (hb) begin
            if (eb[4]) begin wa = w1; uw = 2'd1; end
            if (eb[3:2] == 2'b11) sp_a = 16'(sp - 16'd1);
        end
        ea = model(a, 1'b1, sp_a, wa);
        uw = uw + 2'(ea[4]);
        cy = uw;
        @(negedge clk);
        b_field = 5'(b); a_field = 6'(a); has_b = hb;
        sp_in = sp; ext_word0 = w0; ext_word1 = w1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (hb) begin
            @(negedge clk);
            check(res_valid && !res_is_a && !done, "R10", {res_valid, res_is_a, done}, 3'b100);
            check(actual() == eb, req_of(b), 64'(actual()), 64'(eb));
        end
        @(negedge clk);
        check(res_valid && res_is_a && done, "R10", {res_valid, res_is_a, done}, 3'b111);
        tag = (hb && eb[4] && ea[4]) ? "R9" : req_of(a);
        check(actual() == ea, tag, 64'(actual()), 64'(ea));
        check({sum_words, sum_cycles, sp_final} == {uw, cy, 16'(sp_a + {{14{ea[3]}}, ea[3:2]})},
              "R12", {sum_words, sum_cycles, sp_final},
              {uw, cy, 16'(sp_a + {{14{ea[3]}}, ea[3:2]})});
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            gpr_val[i] = 16'(16'hF000 + i * 16'h1111);
            gpr_bus[i*16 +: 16] = gpr_val[i];
        end
        repeat (3) @(negedge clk);
        // R11: reset state
        check(!busy && !res_valid && !done, "R11", {busy, res_valid, done}, 0);
        check(res_addr == 0 && res_literal == 0 && sp_final == 0 && res_kind == 0 && sum_words == 0,
              "R11", {res_addr, res_literal, sp_final}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // Exhaustive sweep of both fields
        for (int b = 0; b < 32; b++) begin
            for (int a = 0; a < 64; a++) begin
                run_inst(b, a, 1'b1, 16'(b * 16'h0801 + a * 16'h0013),
                         16'(16'hFF00 + a), 16'(16'h1234 ^ b));
            end
        end
        // Single-operand form; R9: a takes ext_word0
        for (int a = 0; a < 64; a++) begin
            run_inst(0, a, 1'b0, 16'(a * 16'h0401), 16'(16'hFFF8 - a), 16'hDEAD);
        end
        // Stack wrap at SP=0: R4 push then pop
        run_inst(24, 24, 1'b1, 16'h0000, 16'h0, 16'h0);
        // R10: start held while busy is ignored
        @(negedge clk);
        b_field = 5'd24; a_field = 6'd24; has_b = 1'b1; sp_in = 16'h0100;
        ext_word0 = 16'h0; ext_word1 = 16'h0; start = 1'b1;
        @(negedge clk);
        b_field = 5'd5; a_field = 6'h21; sp_in = 16'h7777;
        @(negedge clk);
        check(actual() == model(24, 1'b0, 16'h0100, 16'h0), "R4", 64'(actual()), 64'(model(24, 1'b0, 16'h0100, 16'h0)));
        @(negedge clk);
        check(actual() == model(24, 1'b1, 16'h00FF, 16'h0), "R10", 64'(actual()), 64'(model(24, 1'b1, 16'h00FF, 16'h0)));
        start = 1'b0;
        @(negedge clk);
        check(!res_valid && !busy, "R10", {res_valid, busy}, 2'b00);
        @(negedge clk);
        check(!res_valid && !busy, "R10", {res_valid, busy}, 2'b00);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule